// File: doc/BRIEF.md
# OTP Pulse-Programming Sequencer with Verify Retry

This controller burns a word-wide one-time-programmable array from a source buffer. After a start pulse it raises both programming supplies and walks the whole address range once. Each word gets exactly one timed write strobe, with no checking yet. It then goes back to address zero for a second walk. Each word is read back under raised supplies, and any word that does not match gets further strobes. Each word has a bounded number of retries. A third walk drops the supplies to their normal level and compares every word with the source.

The source buffer sits outside the block and is indexed by the same address the block drives to the array. Its word comes back on `src_data` while the address is held. The block waits a parameterised number of clock cycles before it samples read data, so that the array's output-enable delay has passed. All durations are given in microseconds and are scaled by a clock-cycles-per-microsecond parameter.

Top module: `otp_pulse_prog`

## Requirements
- R1: After reset and whenever idle, `busy` and `done` are 0, `mem_ce_n` and `mem_oe_n` are 1, and `vpp_hi` and `vcc_hi` are 0.
- R2: The first walk strobes every address exactly once, in ascending order from 0, and `mem_oe_n` stays 1 until the last address has been strobed.
- R3: A write strobe holds `mem_ce_n` low for exactly PULSE_US*CYC_PER_US cycles. During the strobe `mem_oe_n` is 1 and both `vpp_hi` and `vcc_hi` are 1.
- R4: Before each strobe, address, write data, `mem_oe_n`, `vpp_hi` and `vcc_hi` stay unchanged for at least SETUP_US*CYC_PER_US cycles. After it, address and write data stay unchanged for at least HOLD_US*CYC_PER_US cycles.
- R5: A verify read drives `mem_ce_n`=1 and `mem_oe_n`=0 with both supplies raised. It samples `mem_rdata` only once `mem_oe_n` has been low with a steady address for T_OE = ceil(OE_NS*CYC_PER_US/1000)+1 cycles.
- R6: If a verify read does not match, the word gets one more strobe and is verified again. A word may get at most MAX_TRY extra strobes. If it still mismatches after them, the run ends with `pass`=0, `fail_phase`=2'b01 and `fail_addr` set to that word, and no later word gets an extra strobe.
- R7: When a verify read matches, the walk moves to the next address and the retry budget is renewed, so each word has its own MAX_TRY extra strobes.
- R8: In the final walk both supplies are 0, and each word is read with `mem_ce_n`=0 and `mem_oe_n`=0, with the same sampling delay as R5. The first mismatch ends the run with `pass`=0, `fail_phase`=2'b10 and `fail_addr` set to that word.
- R9: If every final read matches, the run ends with `pass`=1, `fail_phase`=2'b00 and `fail_addr`=0.
- R10: `busy` rises in the cycle after `start` and stays high until `done`. `done` is a one-cycle pulse in the cycle where `busy` falls. A `start` while busy has no effect.
- R11: At the end of a run, pass or fail, the enables return to 1 and the supplies to 0. `pass`, `fail_phase` and `fail_addr` hold their values until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a run |
| src_data | input | DW | Source word for the address on `mem_addr` |
| mem_rdata | input | DW | Word read back from the array |
| mem_addr | output | AW | Array and source address |
| mem_wdata | output | DW | Word to burn |
| mem_ce_n | output | 1 | Array chip enable, active low |
| mem_oe_n | output | 1 | Array output enable, active low |
| vpp_hi | output | 1 | Select raised programming supply |
| vcc_hi | output | 1 | Select raised core supply |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Last run succeeded |
| fail_addr | output | AW | Word that failed |
| fail_phase | output | 2 | 00 none, 01 verify walk, 10 final walk |

## Verification
The cases hardest to reach from the ports are a word that needs exactly the whole retry budget and a word that reads correctly under raised supplies but not at normal ones. The bench's array model holds, for each word, the number of strobes it needs before it reads back the burned value. The model can also mark a word as marginal, which flips a bit only when the core supply is at its normal level. Directed runs place the budget edge (1+MAX_TRY strobes, then one more), several marginal words and several failing words. Seeded random runs then mix these traits, and each run's strobe counts per word and its result are compared with values worked out in the bench.

// File: rtl/otp_pulse_prog.sv
module otp_pulse_prog #(
  parameter int AW         = 8,
  parameter int DW         = 16,
  parameter int CYC_PER_US = 50,
  parameter int PULSE_US   = 100,
  parameter int SETUP_US   = 2,
  parameter int HOLD_US    = 2,
  parameter int OE_NS      = 150,
  parameter int MAX_TRY    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] src_data,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          vpp_hi,
  output logic          vcc_hi,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic [AW-1:0] fail_addr,
  output logic [1:0]    fail_phase
);

  localparam int T_PULSE = PULSE_US * CYC_PER_US;
  localparam int T_SETUP = SETUP_US * CYC_PER_US;
  localparam int T_HOLD  = HOLD_US * CYC_PER_US;
  localparam int T_OE    = (OE_NS * CYC_PER_US + 999) / 1000 + 1;
  localparam int TW      = $clog2(T_PULSE + T_SETUP + T_HOLD + T_OE + 1);
  localparam int CW      = $clog2(MAX_TRY + 1);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_PULSE, S_HOLD, S_VERIFY, S_SETTLE, S_READ
  } st_t;

  st_t           st;
  logic [TW-1:0] tmr;
  logic [AW-1:0] addr;
  logic [CW-1:0] tries;
  logic          second;
  logic          done_q, pass_q;
  logic [AW-1:0] faddr_q;
  logic [1:0]    phase_q;

  wire tick  = (tmr == '0);
  wire match = (mem_rdata == src_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      tmr     <= '0;
      addr    <= '0;
      tries   <= '0;
      second  <= 1'b0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      faddr_q <= '0;
      phase_q <= 2'b00;
    end else begin
      done_q <= 1'b0;
      if (!tick) tmr <= tmr - 1'b1;
      case (st)
        S_IDLE: if (start) begin
          st      <= S_SETUP;
          tmr     <= TW'(T_SETUP - 1);
          addr    <= '0;
          tries   <= '0;
          second  <= 1'b0;
          pass_q  <= 1'b0;
          faddr_q <= '0;
          phase_q <= 2'b00;
        end
        S_SETUP: if (tick) begin
          st  <= S_PULSE;
          tmr <= TW'(T_PULSE - 1);
        end
        S_PULSE: if (tick) begin
          st  <= S_HOLD;
          tmr <= TW'(T_HOLD - 1);
        end
        S_HOLD: if (tick) begin
          if (second || addr == LAST) begin
            st  <= S_VERIFY;
            tmr <= TW'(T_OE - 1);
            if (!second) begin
              second <= 1'b1;
              addr   <= '0;
              tries  <= '0;
            end
          end else begin
            st   <= S_SETUP;
            tmr  <= TW'(T_SETUP - 1);
            addr <= addr + 1'b1;
          end
        end
        S_VERIFY: if (tick) begin
          if (match) begin
            tries <= '0;
            if (addr == LAST) begin
              st   <= S_SETTLE;
              addr <= '0;
              tmr  <= TW'(T_SETUP - 1);
            end else begin
              addr <= addr + 1'b1;
              tmr  <= TW'(T_OE - 1);
            end
          end else if (tries == CW'(MAX_TRY)) begin
            st      <= S_IDLE;
            done_q  <= 1'b1;
            faddr_q <= addr;
            phase_q <= 2'b01;
          end else begin
            tries <= tries + 1'b1;
            st    <= S_SETUP;
            tmr   <= TW'(T_SETUP - 1);
          end
        end
        S_SETTLE: if (tick) begin
          st  <= S_READ;
          tmr <= TW'(T_OE - 1);
        end
        S_READ: if (tick) begin
          if (!match) begin
            st      <= S_IDLE;
            done_q  <= 1'b1;
            faddr_q <= addr;
            phase_q <= 2'b10;
          end else if (addr == LAST) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
            pass_q <= 1'b1;
          end else begin
            addr <= addr + 1'b1;
            tmr  <= TW'(T_OE - 1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  wire raised = (st == S_SETUP) || (st == S_PULSE) || (st == S_HOLD) || (st == S_VERIFY);

  assign mem_addr   = addr;
  assign mem_wdata  = src_data;
  assign mem_ce_n   = !((st == S_PULSE) || (st == S_READ));
  assign mem_oe_n   = !((st == S_VERIFY) || (st == S_READ));
  assign vpp_hi     = raised;
  assign vcc_hi     = raised;
  assign busy       = (st != S_IDLE);
  assign done       = done_q;
  assign pass       = pass_q;
  assign fail_addr  = faddr_q;
  assign fail_phase = phase_q;

  assert_pulse_oe_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && vpp_hi) |-> (mem_oe_n && vcc_hi));

  assert_pulse_lines_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && vpp_hi && $past(!mem_ce_n && vpp_hi)) |-> ($stable(mem_addr) && $stable(mem_wdata)));

  assert_verify_raised_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && mem_ce_n) |-> (vpp_hi && vcc_hi));

  assert_try_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tries <= CW'(MAX_TRY));

  assert_final_normal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !mem_oe_n) |-> (!vpp_hi && !vcc_hi));

  assert_done_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_idle_safe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_ce_n && mem_oe_n && !vpp_hi && !vcc_hi));

endmodule

// File: tb/tb_otp_pulse_prog.sv
`timescale 1ns/1ps
module tb_otp_pulse_prog;
  localparam int AW = 3, DW = 16, CYC = 2, OE_NS = 1500, MAX_TRY = 10;
  localparam int N   = 1 << AW;
  localparam int TP  = 100 * CYC;
  localparam int TS  = 2 * CYC;
  localparam int TH  = 2 * CYC;
  localparam int TOE = (OE_NS * CYC + 999) / 1000 + 1;
  localparam int RTH = TOE - 2;

  logic clk = 0, rst_n = 0, start = 0;
  logic [DW-1:0] src_data, mem_rdata, mem_wdata;
  logic [AW-1:0] mem_addr, fail_addr;
  logic mem_ce_n, mem_oe_n, vpp_hi, vcc_hi, busy, done, pass;
  logic [1:0] fail_phase;

  always #10 clk = ~clk;

  otp_pulse_prog #(.AW(AW), .DW(DW), .CYC_PER_US(CYC), .OE_NS(OE_NS), .MAX_TRY(MAX_TRY)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_data(src_data), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .vpp_hi(vpp_hi), .vcc_hi(vcc_hi), .busy(busy), .done(done), .pass(pass),
    .fail_addr(fail_addr), .fail_phase(fail_phase));

  logic [DW-1:0] src [N];
  logic [DW-1:0] prog [N];
  int  need [N];
  bit  marg [N];
  int  pcnt [N];
  int  ptotal, order_err, width_err, setup_err, hold_err;
  int  n_cmp = 0, n_bad = 0, cycles = 0;

  assign src_data = src[mem_addr];

  logic [AW:0] key, key_q;
  int scnt;
  assign key = {mem_oe_n, mem_addr};
  always @(posedge clk) begin
    scnt  <= (key != key_q || mem_oe_n) ? 0 : scnt + 1;
    key_q <= key;
  end
  always @* begin
    logic [DW-1:0] v;
    bit ok;
    v = (pcnt[mem_addr] >= need[mem_addr]) ? prog[mem_addr] : (prog[mem_addr] ^ 16'h0101);
    if (!vcc_hi && marg[mem_addr]) v = v ^ 16'h8000;
    ok = !mem_oe_n && key == key_q && scnt >= RTH &&
         ((vpp_hi && mem_ce_n) || (!vpp_hi && !mem_ce_n));
    mem_rdata = ok ? v : ~v;
  end

  logic [AW+DW+2:0] k2_q;
  logic [AW+DW-1:0] ad_q;
  int sc = 0, lowc = 0, hc = 1000;
  bit cel_q = 0;
  always @(posedge clk) begin
    logic [AW+DW+2:0] k2;
    bit cel;
    k2 = {mem_addr, mem_wdata, mem_oe_n, vpp_hi, vcc_hi};
    sc = (k2 != k2_q) ? 0 : sc + 1;
    k2_q = k2;
    cel = !mem_ce_n && vpp_hi;
    if ({mem_addr, mem_wdata} != ad_q && hc < TH) hold_err++;
    ad_q = {mem_addr, mem_wdata};
    if (hc < 1000) hc++;
    if (!mem_oe_n && ptotal < N) order_err++;
    if (cel && !cel_q) begin
      if (sc < TS) setup_err++;
      if (ptotal < N && int'(mem_addr) != ptotal) order_err++;
      if (!mem_oe_n || !vcc_hi) width_err++;
      pcnt[mem_addr]++;
      prog[mem_addr] = mem_wdata;
      ptotal++;
      lowc = 0;
    end
    if (cel) lowc++;
    if (!cel && cel_q) begin
      if (lowc != TP) width_err++;
      hc = 1;
    end
    cel_q = cel;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<190000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input bit mid_start);
    int fv, fm, waitc, tot;
    int epc [N];
    bit ep;
    logic [1:0] eph;
    int ea;
    for (int a = 0; a < N; a++) begin
      pcnt[a] = 0; prog[a] = '0;
    end
    ptotal = 0; order_err = 0; width_err = 0; setup_err = 0; hold_err = 0;
    fv = -1; fm = -1; tot = 0;
    for (int a = 0; a < N; a++) if (need[a] > 1 + MAX_TRY && fv < 0) fv = a;
    for (int a = 0; a < N; a++) begin
      epc[a] = (fv < 0 || a < fv) ? need[a] : (a == fv ? 1 + MAX_TRY : 1);
      tot += epc[a];
    end
    if (fv < 0) for (int a = 0; a < N; a++) if (marg[a] && fm < 0) fm = a;
    if (fv >= 0)      begin ep = 0; eph = 2'b01; ea = fv; end
    else if (fm >= 0) begin ep = 0; eph = 2'b10; ea = fm; end
    else              begin ep = 1; eph = 2'b00; ea = 0;  end

    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk(busy == 1, "R10 busy after start", busy, 1);
    if (mid_start) begin
      repeat (500) @(negedge clk);
      start = 1; @(negedge clk) start = 0;
    end
    waitc = 0;
    while (!done && waitc < 60000) begin @(negedge clk); waitc++; end
    chk(done == 1, "R10 done seen", done, 1);
    chk(busy == 0, "R10 busy low with done", busy, 0);
    chk(pass == ep, "R9 pass flag", pass, ep);
    chk(fail_phase == eph, "R6/R8 fail_phase", fail_phase, eph);
    chk(int'(fail_addr) == ea, "R6/R8 fail_addr", fail_addr, ea);
    chk(mem_ce_n && mem_oe_n && !vpp_hi && !vcc_hi, "R11 safe lines at end",
        {mem_ce_n, mem_oe_n, vpp_hi, vcc_hi}, 4'b1100);
    for (int a = 0; a < N; a++)
      chk(pcnt[a] == epc[a], "R7 strobes per word", pcnt[a], epc[a]);
    chk(ptotal == tot, "R10 strobe total (no restart)", ptotal, tot);
    chk(order_err == 0, "R2 first walk order", order_err, 0);
    chk(width_err == 0, "R3 strobe width", width_err, 0);
    chk(setup_err == 0, "R4 setup before strobe", setup_err, 0);
    chk(hold_err == 0, "R4 hold after strobe", hold_err, 0);
    repeat (5) @(negedge clk);
    chk(done == 0, "R10 done one cycle", done, 0);
    chk(pass == ep && fail_phase == eph && int'(fail_addr) == ea, "R11 results held",
        {pass, fail_phase}, {ep, eph});
  endtask

  task automatic clear_pattern();
    for (int a = 0; a < N; a++) begin
      need[a] = 1; marg[a] = 0; src[a] = 16'($urandom);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    clear_pattern();
    ptotal = 0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R1 busy/done at reset", {busy, done}, 0);
    chk(mem_ce_n && mem_oe_n && !vpp_hi && !vcc_hi, "R1 lines at reset",
        {mem_ce_n, mem_oe_n, vpp_hi, vcc_hi}, 4'b1100);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(busy == 0, "R1 idle after reset", busy, 0);

    clear_pattern(); run(0);
    clear_pattern();
    for (int a = 0; a < N; a++) need[a] = 1 + int'($urandom % 4);
    need[2] = 1 + MAX_TRY; need[6] = 1 + MAX_TRY;
    run(1);
    clear_pattern(); need[5] = 2 + MAX_TRY; need[1] = 3; run(0);
    clear_pattern(); need[0] = 2 + MAX_TRY; need[7] = 2 + MAX_TRY; run(0);
    clear_pattern(); marg[3] = 1; marg[6] = 1; need[4] = 5; run(0);
    clear_pattern(); marg[7] = 1; need[7] = 2 + MAX_TRY; marg[0] = 1; run(0);
    for (int r = 0; r < 4; r++) begin
      clear_pattern();
      for (int a = 0; a < N; a++) begin
        need[a] = ($urandom % 10 == 0) ? 2 + MAX_TRY : 1 + int'($urandom % 4);
        marg[a] = ($urandom % 10 == 0);
      end
      run(0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule